// File: doc/BRIEF.md
# Keyed Configuration Access Port

This block is the host-facing configuration window of a legacy-style I/O controller. It occupies two byte addresses on a simple synchronous bus. Offset 0 is the index port and offset 1 is the data port. Software writes a register number to the index port, then reads or writes that register through the data port. Under this window sits a small register space. It holds a logical-device selector, a fixed identification byte, a set of shared global scratch bytes, and a bank of configuration bytes for each logical device. The first byte of each device bank carries that device's activation bit.

The window stays shut until software writes the opening key byte 0x87 to the index port twice in a row. While shut, data writes do nothing and every read returns 0xFF. When software writes the closing byte 0xAA to the index port, the window shuts again.

The control is a three-state machine:
- `CP_LOCKED` is the reset state.
- `CP_HALFKEY` means one key byte has been seen.
- `CP_OPEN` means access is allowed.

The transitions are:
- **arm**: `CP_LOCKED` to `CP_HALFKEY`, on an index write of 0x87.
- **open**: `CP_HALFKEY` to `CP_OPEN`, on an index write of 0x87.
- **abort**: `CP_HALFKEY` to `CP_LOCKED`, on any other index write or on any data write.
- **close**: `CP_OPEN` to `CP_LOCKED`, on an index write of 0xAA.
- Every other access leaves the state as it is.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the port is locked, the index and the device selector are 0x00, every stored register is 0x00, `dev_active` is all zero, and `rdata` is 0xFF.
- R2: While the port is not open, data-port writes change no register, and a read at either address returns 0xFF.
- R3: The port opens only on the second of two consecutive index-port writes of 0x87. Any other index-port write, or any data-port write, between the two keys restarts the sequence.
- R4: While the port is open, an index-port write of 0xAA locks the port and leaves the stored index unchanged.
- R5: While the port is open, any other index-port write stores its byte as the index. A read of the index port returns the stored index.
- R6: Index 0x07 is the device selector. It can be read and written through the data port.
- R7: Index 0x20 always reads as the parameter `CHIP_ID`. Writes to it are ignored.
- R8: Indices 0x30 to 0x30+BANK_REGS-1 are banked. Each logical device below `NUM_DEV` has its own copy, and accesses go to the device named by the selector.
- R9: `dev_active[d]` equals bit 0 of device d's register at index 0x30.
- R10: Indices 0x21 to 0x2F are global read/write bytes, shared by all devices.
- R11: Every other index reads 0x00 and ignores writes. When the selector is NUM_DEV or higher, banked indices read 0x00 and ignore writes.
- R12: A read puts its value on `rdata` at the first clock edge where `rd_en` is high. `rdata` holds that value until the next read. A read in the same cycle as a write sees the state before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Activation bit of each logical device |

## Verification
A wrong key-sequence state shows up at once. The first read after the bad transition returns 0xFF where register data was expected, or register data where 0xFF was expected. A wrong stored index or selector corrupts the value of the very next data-port read. A bank write steered to the wrong device shows on `dev_active` one cycle after that write, or on a later read of the other device. The random stream mixes key bytes, close bytes and register indices. Because of this, partial key sequences, aborted keys and relocks all occur many times, and a reference model checks each one.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    typedef enum logic [1:0] {
        CP_LOCKED  = 2'd0,
        CP_HALFKEY = 2'd1,
        CP_OPEN    = 2'd2
    } cp_state_e;

    localparam logic [7:0] KEY_OPEN   = 8'h87;
    localparam logic [7:0] KEY_CLOSE  = 8'hAA;
    localparam logic [7:0] IDX_DEVSEL = 8'h07;
    localparam logic [7:0] IDX_CHIPID = 8'h20;
    localparam logic [7:0] IDX_GLB_LO = 8'h21;
    localparam logic [7:0] IDX_GLB_HI = 8'h2F;
    localparam logic [7:0] IDX_BANK0  = 8'h30;
    localparam logic [7:0] LOCKED_RD  = 8'hFF;
endpackage

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr_i,
    input  logic       dat_wr_i,
    input  logic [7:0] wdata_i,
    output logic       open_o,
    output logic       idx_load_o
);
    cp_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CP_LOCKED;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CP_LOCKED: begin
                if (idx_wr_i && wdata_i == KEY_OPEN) st_d = CP_HALFKEY;      // arm
            end
            CP_HALFKEY: begin
                if (idx_wr_i) st_d = (wdata_i == KEY_OPEN) ? CP_OPEN : CP_LOCKED; // open / abort
                else if (dat_wr_i) st_d = CP_LOCKED;                          // abort
            end
            CP_OPEN: begin
                if (idx_wr_i && wdata_i == KEY_CLOSE) st_d = CP_LOCKED;      // close
            end
            default: st_d = CP_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        open_o     = (st_q == CP_OPEN);
        idx_load_o = (st_q == CP_OPEN) && idx_wr_i && (wdata_i != KEY_CLOSE);
    end

    // R3: the open state is only reached from the half key by a second key write
    p_open_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == CP_OPEN) |-> ($past(st_q) == CP_HALFKEY && $past(idx_wr_i) && $past(wdata_i) == KEY_OPEN));

    // R4: the close byte written while open always locks
    p_close_locks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CP_OPEN && idx_wr_i && wdata_i == KEY_CLOSE) |=> (st_q == CP_LOCKED));

    // R3: a data write during the half key aborts the sequence
    p_data_aborts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CP_HALFKEY && !idx_wr_i && dat_wr_i) |=> (st_q == CP_LOCKED));
endmodule

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int         NUM_DEV   = 16,
    parameter int         BANK_REGS = 16,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_i,
    input  logic               idx_load_i,
    input  logic               dat_wr_i,
    input  logic [7:0]         wdata_i,
    output logic [7:0]         index_o,
    output logic [7:0]         dat_rd_o,
    output logic [NUM_DEV-1:0] dev_active_o
);
    localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int BOFF_W = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
    localparam int GLB_N  = int'(IDX_GLB_HI) - int'(IDX_GLB_LO) + 1;
    localparam int GOFF_W = $clog2(GLB_N);

    logic [7:0] index_q, sel_q;
    logic [7:0] glb_q  [GLB_N];
    logic [7:0] bank_q [NUM_DEV][BANK_REGS];

    logic [7:0] boff, goff;
    logic       sel_ok, in_bank, in_glb, wr_ok;
    logic       sel_we, glb_we, bank_we;

    always_comb begin
        boff    = index_q - IDX_BANK0;
        goff    = index_q - IDX_GLB_LO;
        sel_ok  = ({1'b0, sel_q} < 9'(NUM_DEV));
        in_bank = (index_q >= IDX_BANK0) && ({1'b0, boff} < 9'(BANK_REGS));
        in_glb  = (index_q >= IDX_GLB_LO) && (index_q <= IDX_GLB_HI);
        wr_ok   = open_i && dat_wr_i;
        sel_we  = wr_ok && (index_q == IDX_DEVSEL);
        glb_we  = wr_ok && in_glb;
        bank_we = wr_ok && in_bank && sel_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          index_q <= 8'h00;
        else if (idx_load_i) index_q <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= 8'h00;
        else if (sel_we) sel_q <= wdata_i;
    end

    for (genvar g = 0; g < GLB_N; g++) begin : g_glb
        always_ff @(posedge clk) begin
            if (!rst_n)                             glb_q[g] <= 8'h00;
            else if (glb_we && goff == 8'(g))       glb_q[g] <= wdata_i;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        for (genvar r = 0; r < BANK_REGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank_q[d][r] <= 8'h00;
                else if (bank_we && sel_q == 8'(d) && boff == 8'(r))
                    bank_q[d][r] <= wdata_i;
            end
        end
        assign dev_active_o[d] = bank_q[d][0][0];
    end

    // Data-port read mux
    always_comb begin
        dat_rd_o = 8'h00;
        if (index_q == IDX_DEVSEL)      dat_rd_o = sel_q;
        else if (index_q == IDX_CHIPID) dat_rd_o = CHIP_ID;
        else if (in_glb)                dat_rd_o = glb_q[goff[GOFF_W-1:0]];
        else if (in_bank && sel_ok)     dat_rd_o = bank_q[sel_q[SEL_W-1:0]][boff[BOFF_W-1:0]];
    end

    assign index_o = index_q;

    // R5: the index only moves on a load issued by the key machine
    p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_load_i |=> $stable(index_q));

    // R2: while not open the selector cannot change
    p_locked_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(sel_q));

    // R2: while not open no device activation bit changes
    p_locked_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> $stable(dev_active_o));
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfgport_pkg::*;
#(
    parameter int         NUM_DEV   = 16,
    parameter int         BANK_REGS = 16,
    parameter logic [7:0] CHIP_ID   = 8'h5C
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [NUM_DEV-1:0] dev_active
);
    logic idx_wr, dat_wr, open_s, idx_load;
    logic [7:0] index_s, dat_rd_s, rdata_q;

    assign idx_wr = wr_en && !addr;
    assign dat_wr = wr_en && addr;

    cfgport_keyfsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr_i   (idx_wr),
        .dat_wr_i   (dat_wr),
        .wdata_i    (wdata),
        .open_o     (open_s),
        .idx_load_o (idx_load)
    );

    cfgport_regs #(
        .NUM_DEV   (NUM_DEV),
        .BANK_REGS (BANK_REGS),
        .CHIP_ID   (CHIP_ID)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .open_i       (open_s),
        .idx_load_i   (idx_load),
        .dat_wr_i     (dat_wr),
        .wdata_i      (wdata),
        .index_o      (index_s),
        .dat_rd_o     (dat_rd_s),
        .dev_active_o (dev_active)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= LOCKED_RD;
        else if (rd_en) begin
            if (!open_s)    rdata_q <= LOCKED_RD;
            else if (!addr) rdata_q <= index_s;
            else            rdata_q <= dat_rd_s;
        end
    end
    assign rdata = rdata_q;

    // R2: a read while not open yields 0xFF
    p_locked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !open_s) |=> (rdata == LOCKED_RD));

    // R7: the identification index reads the fixed byte
    p_chip_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && open_s && addr && index_s == IDX_CHIPID) |=> (rdata == CHIP_ID));

    // R12: rdata holds between reads
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/cfg_keyport_test.sv
`timescale 1ns/1ps
module cfg_keyport_test;
    localparam int         NDEV = 16;
    localparam int         NBR  = 16;
    localparam logic [7:0] CID  = 8'h5C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [NDEV-1:0] dev_active;

    always #2 clk = ~clk;

    cfg_keyport #(.NUM_DEV(NDEV), .BANK_REGS(NBR), .CHIP_ID(CID)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .dev_active(dev_active)
    );

    int checks = 0;
    int fails = 0;
    bit timed_out = 0;

    // Reference model: 0 locked, 1 half key, 2 open
    int         m_st;
    logic [7:0] m_idx, m_sel;
    logic [7:0] m_glb  [15];
    logic [7:0] m_bank [NDEV][NBR];

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_idx = 8'h00; m_sel = 8'h00;
        for (int i = 0; i < 15; i++) m_glb[i] = 8'h00;
        for (int d = 0; d < NDEV; d++)
            for (int r = 0; r < NBR; r++) m_bank[d][r] = 8'h00;
    endtask

    function automatic logic [7:0] exp_data();
        if (m_idx == 8'h07) return m_sel;
        if (m_idx == 8'h20) return CID;
        if (m_idx >= 8'h21 && m_idx <= 8'h2F) return m_glb[m_idx - 8'h21];
        if (m_idx >= 8'h30 && int'(m_idx) < 8'h30 + NBR && int'(m_sel) < NDEV)
            return m_bank[m_sel][m_idx - 8'h30];
        return 8'h00;
    endfunction

    function automatic logic [NDEV-1:0] exp_act();
        logic [NDEV-1:0] v;
        for (int d = 0; d < NDEV; d++) v[d] = m_bank[d][0][0];
        return v;
    endfunction

    task automatic model_write(input logic a, input logic [7:0] v);
        if (!a) begin
            case (m_st)
                0: m_st = (v == 8'h87) ? 1 : 0;
                1: m_st = (v == 8'h87) ? 2 : 0;
                default: if (v == 8'hAA) m_st = 0; else m_idx = v;
            endcase
        end else begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
                if (m_idx == 8'h07) m_sel = v;
                else if (m_idx >= 8'h21 && m_idx <= 8'h2F) m_glb[m_idx - 8'h21] = v;
                else if (m_idx >= 8'h30 && int'(m_idx) < 8'h30 + NBR && int'(m_sel) < NDEV)
                    m_bank[m_sel][m_idx - 8'h30] = v;
            end
        end
    endtask

    task automatic do_wr(input logic a, input logic [7:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(a, v);
    endtask

    task automatic do_rd(input logic a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        if (m_st != 2) e = 8'hFF;
        else if (!a)   e = m_idx;
        else           e = exp_data();
        @(posedge clk); #1;
        rd_en = 1'b0;
        chk(32'(rdata), 32'(e), tag);
    endtask

    task automatic unlock();
        do_wr(1'b0, 8'h87);
        do_wr(1'b0, 8'h87);
    endtask

    task automatic run_all();
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(32'(rdata), 32'hFF, "R1 rdata after reset");
        chk(32'(dev_active), 32'h0, "R1 dev_active after reset");
        // R2 locked access
        do_wr(1'b1, 8'h55);
        do_rd(1'b1, "R2 locked data read");
        do_rd(1'b0, "R2 locked index read");
        // R3 aborted sequences
        do_wr(1'b0, 8'h87); do_wr(1'b1, 8'h11); do_wr(1'b0, 8'h87);
        do_rd(1'b0, "R3 data write aborts key");
        do_wr(1'b0, 8'h12); do_wr(1'b0, 8'h87);
        do_rd(1'b0, "R3 other index aborts key");
        do_wr(1'b0, 8'h87);
        do_rd(1'b0, "R3 two keys open, index reads zero");
        // R5 index
        do_wr(1'b0, 8'h3C);
        do_rd(1'b0, "R5 index readback");
        // R7 chip id
        do_wr(1'b0, 8'h20); do_wr(1'b1, 8'h00);
        do_rd(1'b1, "R7 chip id");
        // R6/R9 select and activate device 8
        do_wr(1'b0, 8'h07); do_wr(1'b1, 8'h08);
        do_rd(1'b1, "R6 selector readback");
        do_wr(1'b0, 8'h30); do_wr(1'b1, 8'h01);
        @(negedge clk);
        chk(32'(dev_active), 32'(16'h0100), "R9 device 8 active");
        // R8 banks separate
        do_wr(1'b0, 8'h07); do_wr(1'b1, 8'h03);
        do_wr(1'b0, 8'h30);
        do_rd(1'b1, "R8 device 3 bank untouched");
        // R10 global shared
        do_wr(1'b0, 8'h25); do_wr(1'b1, 8'hC3);
        do_wr(1'b0, 8'h07); do_wr(1'b1, 8'h08);
        do_wr(1'b0, 8'h25);
        do_rd(1'b1, "R10 global visible from other device");
        // R11 unused and out-of-range selector
        do_wr(1'b0, 8'h05); do_wr(1'b1, 8'h77);
        do_rd(1'b1, "R11 unused index reads zero");
        do_wr(1'b0, 8'h07); do_wr(1'b1, 8'h40);
        do_wr(1'b0, 8'h30); do_wr(1'b1, 8'hEE);
        do_rd(1'b1, "R11 out-of-range device reads zero");
        // R12 hold
        do_wr(1'b0, 8'h20);
        do_rd(1'b1, "R12 read value");
        repeat (5) @(negedge clk);
        chk(32'(rdata), 32'(CID), "R12 rdata holds");
        // R4 relock keeps index
        do_wr(1'b0, 8'hAA);
        do_rd(1'b1, "R4 relocked read");
        unlock();
        do_rd(1'b0, "R4 index kept over relock");
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int kind;
            logic [7:0] v;
            kind = $urandom_range(0, 9);
            case ($urandom_range(0, 7))
                0, 1: v = 8'h87;
                2:    v = 8'hAA;
                3:    v = 8'h07;
                4:    v = 8'h30 + 8'($urandom_range(0, NBR));
                5:    v = 8'h20 + 8'($urandom_range(0, 15));
                6:    v = 8'($urandom_range(0, 19));
                default: v = 8'($urandom);
            endcase
            if (kind < 4)      do_wr(1'b0, v);
            else if (kind < 7) do_wr(1'b1, (v == 8'h07) ? 8'h01 : 8'($urandom));
            else               do_rd(kind[0], "R8 random access");
            if (n % 8 == 0) begin
                @(negedge clk);
                chk(32'(dev_active), 32'(exp_act()), "R9 random dev_active");
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule